// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block turns single-byte host requests into correctly timed cycles on an 8-bit NAND flash bus. The host has four request strobes: command, address, write-data and read-data. All three write strobes share one byte input. Each accepted request becomes one bus access. The block drives the command-latch and address-latch enables, the active-low write and read strobes, and the data bus together with its output enable.

Every access has three parts, and their lengths come from a small configuration register. First comes a setup stretch, then the strobe-low stretch, then a hold stretch. Each field stores the wanted number of clocks minus one. The same register holds the active-low chip-enable bit, which drives the chip-enable pin directly. The flash ready/busy pin passes through a synchronizer and appears as a status bit. While an access runs, the block reports busy and ignores new requests. Writes to the configuration register are also ignored while busy.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset the configuration output reads all ones: setup field bits [1:0] = 3, strobe field bits [4:2] = 7, hold field bits [7:5] = 7, chip-off bit [8] = 1. In this state the bus is idle: chip enable high, write and read strobes high, both latch enables low, data output enable low, busy low.
- R2: An accepted access takes (setup+1) clocks of setup with both strobes high, then (strobe+1) clocks with the access strobe low, then (hold+1) clocks of hold. Busy is high for exactly these clocks. Setup therefore spans 1 to 4 clocks, and strobe and hold each span 1 to 8.
- R3: A command-port request holds the command latch enable high for the whole access, keeps the address latch enable low, and pulses the write strobe.
- R4: An address-port request holds the address latch enable high for the whole access, keeps the command latch enable low, and pulses the write strobe.
- R5: For any write request, the data output enable is high with the request byte on the data bus from the first setup clock to the last hold clock. It is low at all other times.
- R6: A read request pulses the read strobe with both latch enables low and the output enable low. The data bus is sampled on the clock edge that ends the strobe stretch. The read-valid output is high for exactly one clock, and read data holds the sampled byte.
- R7: Requests and configuration writes that arrive while busy are ignored. They start no second access, do not change the bus byte, and do not change the configuration.
- R8: When several request strobes are high in the same idle clock, exactly one access starts. The priority is command, then address, then write-data, then read-data.
- R9: Configuration bit [8] drives the chip-enable pin. Writing 1 de-asserts the chip and writing 0 selects it, effective one clock after the write.
- R10: The ready status equals the ready/busy pin delayed by two clock edges: 1 means ready, 0 means busy.
- R11: The write and read strobes are never low together, and the two latch enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command request strobe |
| addr_wr | input | 1 | Address request strobe |
| data_wr | input | 1 | Write-data request strobe |
| data_rd | input | 1 | Read-data request strobe |
| wr_byte | input | 8 | Byte for command, address or data writes |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration value |
| cfg_q | output | 9 | Current configuration |
| busy | output | 1 | Access in progress |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | One-clock pulse when rd_data is updated |
| status_ready | output | 1 | Synchronized ready status |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb | input | 1 | Flash ready/busy pin, 1 = ready |

## Verification
The bench builds the block with its default parameters: a 2-bit setup field, 3-bit strobe and hold fields, 8-bit data and a two-stage synchronizer. With these widths, random field values reach every legal length, from the 1-clock minimum of each stretch to the 4- and 8-clock maxima. That covers both the shortest 3-clock access and the longest 20-clock access. The small setup ceiling also means the reset default is reached when all field bits are set.

// File: rtl/nbs_pkg.sv
`timescale 1ns/1ps
package nbs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } nbs_phase_e;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WDATA = 2'd2,
    OP_RDATA = 2'd3
  } nbs_op_e;
endpackage

// File: rtl/nbs_cfg_reg.sv
`timescale 1ns/1ps
module nbs_cfg_reg #(
  parameter int SETUP_W = 2,
  parameter int PHASE_W = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic                             busy_i,
  input  logic [SETUP_W+2*PHASE_W:0]       wdata,
  output logic [SETUP_W+2*PHASE_W:0]       cfg_q,
  output logic [SETUP_W-1:0]               setup_m1,
  output logic [PHASE_W-1:0]               strobe_m1,
  output logic [PHASE_W-1:0]               hold_m1,
  output logic                             chip_off
);
  localparam int CFG_W    = SETUP_W + 2*PHASE_W + 1;
  localparam int STB_LO   = SETUP_W;
  localparam int HLD_LO   = SETUP_W + PHASE_W;
  localparam int OFF_BIT  = SETUP_W + 2*PHASE_W;
  localparam logic [CFG_W-1:0] CFG_RST = {CFG_W{1'b1}};

  logic [CFG_W-1:0] cfg_d;
  logic             cfg_en;

  assign cfg_en = wr_en & ~busy_i;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_en) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_d;
  end

  assign setup_m1  = cfg_q[SETUP_W-1:0];
  assign strobe_m1 = cfg_q[STB_LO +: PHASE_W];
  assign hold_m1   = cfg_q[HLD_LO +: PHASE_W];
  assign chip_off  = cfg_q[OFF_BIT];

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(cfg_q)); // R7
endmodule

// File: rtl/nbs_rb_sync.sv
`timescale 1ns/1ps
module nbs_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_in,
  output logic ready_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = rb_in;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], rb_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ready_o = sh_q[STAGES-1];

  logic [1:0] settle_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              settle_q <= 2'd0;
    else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      AST_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q >= 2'd2) |-> (ready_o == $past(rb_in, 2))); // R10
    end
  endgenerate
endmodule

// File: rtl/nbs_access_fsm.sv
`timescale 1ns/1ps
module nbs_access_fsm
  import nbs_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SETUP_W = 2,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic               addr_wr,
  input  logic               data_wr,
  input  logic               data_rd,
  input  logic [DATA_W-1:0]  wr_byte,
  input  logic [SETUP_W-1:0] setup_m1,
  input  logic [PHASE_W-1:0] strobe_m1,
  input  logic [PHASE_W-1:0] hold_m1,
  input  logic [DATA_W-1:0]  dq_in,
  output logic               busy,
  output logic               cle,
  output logic               ale,
  output logic               we_n,
  output logic               re_n,
  output logic [DATA_W-1:0]  dq_out,
  output logic               dq_oe,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid
);
  localparam int CNT_W = (SETUP_W > PHASE_W) ? SETUP_W : PHASE_W;

  nbs_phase_e        phase_q, phase_d;
  nbs_op_e           op_q, op_d, sel_op;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;
  logic              start, capture, cnt_zero;

  assign start    = cmd_wr | addr_wr | data_wr | data_rd;
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    if (cmd_wr)       sel_op = OP_CMD;
    else if (addr_wr) sel_op = OP_ADDR;
    else if (data_wr) sel_op = OP_WDATA;
    else              sel_op = OP_RDATA;
  end

  always_comb begin
    phase_d = phase_q;
    op_d    = op_q;
    cnt_d   = cnt_q;
    byte_d  = byte_q;
    capture = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          op_d    = sel_op;
          cnt_d   = CNT_W'(setup_m1);
          byte_d  = wr_byte;
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_STROBE;
          cnt_d   = CNT_W'(strobe_m1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          phase_d = PH_HOLD;
          cnt_d   = CNT_W'(hold_m1);
          capture = (op_q == OP_RDATA);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (cnt_zero) phase_d = PH_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_CMD;
      cnt_q   <= '0;
      byte_q  <= '0;
    end else begin
      phase_q <= phase_d;
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= capture;
      if (capture) rd_data_q <= dq_in;
    end
  end

  logic active, strobing, is_read;
  assign active   = (phase_q != PH_IDLE);
  assign strobing = (phase_q == PH_STROBE);
  assign is_read  = (op_q == OP_RDATA);

  assign busy     = active;
  assign cle      = active & (op_q == OP_CMD);
  assign ale      = active & (op_q == OP_ADDR);
  assign we_n     = ~(strobing & ~is_read);
  assign re_n     = ~(strobing & is_read);
  assign dq_oe    = active & ~is_read;
  assign dq_out   = byte_q;
  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n)); // R11
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R11
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> busy); // R2
  AST_DQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out)); // R5
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!re_n) && !re_n == 1'b0)); // R6
endmodule

// File: rtl/nand_bus_seq.sv
`timescale 1ns/1ps
module nand_bus_seq #(
  parameter int DATA_W      = 8,
  parameter int SETUP_W     = 2,
  parameter int PHASE_W     = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W      = SETUP_W + 2*PHASE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              addr_wr,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              status_ready,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb
);
  logic [1:0] rst_sh_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_s_n = rst_sh_q[1];

  logic [SETUP_W-1:0] setup_m1;
  logic [PHASE_W-1:0] strobe_m1, hold_m1;
  logic               chip_off;
  logic               busy_w;

  nbs_cfg_reg #(.SETUP_W(SETUP_W), .PHASE_W(PHASE_W)) u_cfg (
    .clk(clk), .rst_n(rst_s_n), .wr_en(cfg_wr), .busy_i(busy_w),
    .wdata(cfg_wdata), .cfg_q(cfg_q), .setup_m1(setup_m1),
    .strobe_m1(strobe_m1), .hold_m1(hold_m1), .chip_off(chip_off)
  );

  nbs_access_fsm #(.DATA_W(DATA_W), .SETUP_W(SETUP_W), .PHASE_W(PHASE_W)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .cmd_wr(cmd_wr), .addr_wr(addr_wr),
    .data_wr(data_wr), .data_rd(data_rd), .wr_byte(wr_byte),
    .setup_m1(setup_m1), .strobe_m1(strobe_m1), .hold_m1(hold_m1),
    .dq_in(nand_dq_in), .busy(busy_w), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .dq_out(nand_dq_out),
    .dq_oe(nand_dq_oe), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  nbs_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .rb_in(nand_rb), .ready_o(status_ready)
  );

  assign busy      = busy_w;
  assign nand_ce_n = chip_off;

  AST_CE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($past(cfg_wr) && !$past(busy_w)) |-> (nand_ce_n == $past(cfg_wdata[CFG_W-1]))); // R9
endmodule

// File: tb/sim_nand_bus_seq.sv
`timescale 1ns/1ps
module sim_nand_bus_seq;
  localparam int CFG_W = 9;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_wr, addr_wr, data_wr, data_rd, cfg_wr, nand_rb;
  logic [7:0] wr_byte, flash_val;
  logic [8:0] cfg_wdata;
  logic [8:0] cfg_q;
  logic       busy, rd_valid, status_ready, nand_ce_n, nand_cle, nand_ale;
  logic       nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] rd_data, nand_dq_out, nand_dq_in;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  assign nand_dq_in = nand_re_n ? ~flash_val : flash_val;

  nand_bus_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .addr_wr(addr_wr),
    .data_wr(data_wr), .data_rd(data_rd), .wr_byte(wr_byte),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid), .status_ready(status_ready),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_op(input logic [3:0] m);
    if (m[0]) return 0;
    if (m[1]) return 1;
    if (m[2]) return 2;
    return 3;
  endfunction

  function automatic logic [8:0] pack_cfg(input int s, input int w, input int h, input bit off);
    return {off, 3'(h - 1), 3'(w - 1), 2'(s - 1)};
  endfunction

  task automatic write_cfg(input logic [8:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // mask bit0 cmd, bit1 addr, bit2 wdata, bit3 rdata; inject: request+cfg during busy
  task automatic access(input logic [3:0] m, input logic [7:0] b, input int es,
                        input int ew, input int eh, input bit inject);
    int op, s, w, h, n, rv, bad_cle, bad_ale, bad_oe, bad_dq;
    bit seen;
    logic [8:0] cfg_before;
    op = exp_op(m);
    s = 0; w = 0; h = 0; n = 0; rv = 0; seen = 0;
    bad_cle = 0; bad_ale = 0; bad_oe = 0; bad_dq = 0;
    cfg_before = cfg_q;
    flash_val = 8'($urandom);
    @(negedge clk);
    {data_rd, data_wr, addr_wr, cmd_wr} = m; wr_byte = b;
    @(negedge clk);
    {data_rd, data_wr, addr_wr, cmd_wr} = 4'b0;
    while (busy && n < 64) begin
      if (inject && n == 1) begin
        data_wr = 1'b1; cmd_wr = 1'b1; wr_byte = ~b;
        cfg_wr = 1'b1; cfg_wdata = ~cfg_q;
      end else begin
        data_wr = 1'b0; cmd_wr = 1'b0; cfg_wr = 1'b0;
      end
      if ((op == 3 ? nand_re_n : nand_we_n) == 1'b0) begin w++; seen = 1; end
      else if (!seen) s++;
      else h++;
      if (nand_cle != (op == 0)) bad_cle++;
      if (nand_ale != (op == 1)) bad_ale++;
      if (nand_dq_oe != (op != 3)) bad_oe++;
      if (op != 3 && nand_dq_out != b) bad_dq++;
      if (rd_valid) rv++;
      n++;
      @(negedge clk);
    end
    data_wr = 1'b0; cmd_wr = 1'b0; cfg_wr = 1'b0;
    if (rd_valid) rv++;
    chk(s == es, "R2 setup clocks", s, es);
    chk(w == ew, "R2 strobe clocks", w, ew);
    chk(h == eh, "R2 hold clocks", h, eh);
    chk(bad_cle == 0, "R3 command latch level", bad_cle, 0);
    chk(bad_ale == 0, "R4 address latch level", bad_ale, 0);
    chk(bad_oe == 0 && bad_dq == 0, "R5 bus drive", bad_oe + bad_dq, 0);
    if (op == 3) begin
      chk(rv == 1, "R6 read valid pulses", rv, 1);
      chk(rd_data == flash_val, "R6 read byte", rd_data, flash_val);
    end else begin
      chk(rv == 0, "R6 no read valid on write", rv, 0);
    end
    chk(!nand_dq_oe && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
        "R11 idle bus after access", nand_dq_oe, 0);
    if (inject) begin
      @(negedge clk);
      chk(busy == 1'b0, "R7 no second access", busy, 0);
      chk(cfg_q == cfg_before, "R7 config unchanged", cfg_q, cfg_before);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    {cmd_wr, addr_wr, data_wr, data_rd, cfg_wr} = 5'b0;
    wr_byte = 8'h00; cfg_wdata = 9'h000; nand_rb = 1'b0; flash_val = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and default timings
    chk(cfg_q == 9'h1FF, "R1 config default", cfg_q, 9'h1FF);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale &&
        !nand_dq_oe && !busy, "R1 idle outputs", busy, 0);
    access(4'b0001, 8'hA5, 4, 8, 8, 1'b0); // R1 defaults 4/8/8

    // R9 chip enable
    write_cfg(pack_cfg(1, 1, 1, 1'b0));
    chk(nand_ce_n == 1'b0, "R9 chip selected", nand_ce_n, 0);
    write_cfg(pack_cfg(1, 1, 1, 1'b1));
    chk(nand_ce_n == 1'b1, "R9 chip deselected", nand_ce_n, 1);

    // minimum lengths, each op
    access(4'b0001, 8'h3C, 1, 1, 1, 1'b0);
    access(4'b0010, 8'h5A, 1, 1, 1, 1'b0);
    access(4'b0100, 8'hF0, 1, 1, 1, 1'b0);
    access(4'b1000, 8'h00, 1, 1, 1, 1'b0);

    // R8 priority
    write_cfg(pack_cfg(2, 3, 2, 1'b0));
    access(4'b1011, 8'h11, 2, 3, 2, 1'b0);
    access(4'b1110, 8'h22, 2, 3, 2, 1'b0);
    access(4'b1100, 8'h33, 2, 3, 2, 1'b0);

    // R7 ignored requests and config writes while busy
    access(4'b0100, 8'h6B, 2, 3, 2, 1'b1);
    access(4'b1000, 8'h00, 2, 3, 2, 1'b1);

    // R10 ready synchronizer
    @(negedge clk); nand_rb = 1'b1;
    @(negedge clk);
    chk(status_ready == 1'b0, "R10 one edge still busy", status_ready, 0);
    @(negedge clk);
    chk(status_ready == 1'b1, "R10 two edges ready", status_ready, 1);
    nand_rb = 1'b0;
    @(negedge clk);
    chk(status_ready == 1'b1, "R10 one edge still ready", status_ready, 1);
    @(negedge clk);
    chk(status_ready == 1'b0, "R10 two edges busy", status_ready, 0);

    // random timings and ops
    for (int i = 0; i < 60; i++) begin
      int s, w, h;
      logic [3:0] m;
      s = 1 + int'($urandom_range(0, 3));
      w = 1 + int'($urandom_range(0, 7));
      h = 1 + int'($urandom_range(0, 7));
      m = 4'($urandom_range(1, 15));
      write_cfg(pack_cfg(s, w, h, 1'($urandom)));
      access(m, 8'($urandom), s, w, h, (i % 7) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule